// File: doc/BRIEF.md
# Manual Line-Encryption Sequencer

This block is the register-facing front end of a manual encryption job for an external flash controller. Software loads up to 64 bytes of plaintext into a word-addressed buffer, chooses how many bytes make up the line (16, 32 or 64), and sets the physical flash address and the destination. It then writes a start command. The block checks the line configuration and starts an external cipher engine. The engine reads plaintext words through an index port and returns ciphertext words, which are captured into a result buffer.

Results pass through two stages. After the cipher finishes, the result is held but kept dark toward the memory-interface side. Only a release command makes it readable there. A wipe command zeroes the result buffer and returns the block to idle. A 2-bit status code shows the stage, and each command is legal in exactly one stage. A command given in any other stage is refused and raises a sticky error flag. The block also holds a side-channel-protection control word and drives its fields as outputs.

The state machine has four states:
- ST_IDLE (code 0): a valid start moves it to ST_BUSY.
- ST_BUSY (code 1): the engine's done strobe moves it to ST_HIDDEN.
- ST_HIDDEN (code 2): release moves it to ST_VISIBLE.
- ST_VISIBLE (code 3): wipe moves it back to ST_IDLE and clears the result buffer.

Every other combination of command and state keeps the state and sets the error flag.

Top module: `mce_ctrl`

## Requirements
- R1: After reset:
  - status reads 0 and the error flag is 0;
  - line size, destination and address read 0;
  - the protection word reads 0x0F: level 7 in bits 2:0, dual-key bit 3 = 1, select bit 4 = 0;
  - the version register at 0x35C reads 0x20201010.
- R2: Writing 1 to bit 0 of the start register (0x34C) in state 0, with a valid line configuration, moves status to 1 (busy) and raises `eng_start` for exactly one cycle, in the first cycle of state 1.
- R3: While in state 1, engine result writes are stored at their word index. When `eng_done` arrives in state 1, status becomes 2 in the next cycle. Result writes in any other state are ignored.
- R4: `mem_visible` is 1 only in state 3. `mem_rd_data` returns the stored result word in state 3 and 0 in every other state.
- R5: Release (bit 0 of 0x350) is honoured only in state 2 and moves status to 3. Wipe (bit 0 of 0x354) is honoured only in state 3, returns status to 0 and zeroes every result word.
- R6: A command written in a state where it is illegal leaves status unchanged and sets the sticky error flag (status bit 8). Writing 1 to bit 8 of the status register (0x358) clears the flag.
- R7: A start is rejected (error set, status stays 0, no `eng_start`) if line size is 3 or if the address is not a multiple of the line's byte count. Line size codes: 0 = 16 bytes, 1 = 32 bytes, 2 = 64 bytes.
- R8: The three command registers always read 0. A write with bit 0 = 0 to any of them has no effect and sets no error.
- R9: Register map:
  - plaintext words at 0x300–0x33C, read/write;
  - line size at bits 1:0 of 0x340;
  - destination at bit 0 of 0x344;
  - address at bits 25:0 of 0x348;
  - status: state in bits 1:0, error in bit 8, at 0x358;
  - protection word at bits 4:0 of 0x388;
  - unmapped offsets read 0.
- R10: `sec_level` drives protection bits 2:0 and `prot_sel` drives bit 4. `dual_key_en` is bit 3 gated by a nonzero level.
- R11: `eng_pt_data` returns the plaintext word selected by `eng_pt_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 10 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| eng_start | output | 1 | One-cycle start pulse to the cipher engine |
| eng_lsize | output | 2 | Line size code |
| eng_paddr | output | 26 | Physical flash address |
| eng_dest | output | 1 | Destination select |
| eng_pt_idx | input | 4 | Plaintext word index requested by the engine |
| eng_pt_data | output | 32 | Plaintext word at `eng_pt_idx` |
| eng_done | input | 1 | Engine completion strobe |
| eng_res_we | input | 1 | Result word write strobe |
| eng_res_idx | input | 4 | Result word index |
| eng_res_data | input | 32 | Result word |
| mem_visible | output | 1 | Result visible to the memory-interface side |
| mem_rd_idx | input | 4 | Result word index, memory side |
| mem_rd_data | output | 32 | Result word, or 0 when not visible |
| sec_level | output | 3 | Protection level |
| dual_key_en | output | 1 | Protection on both keys (effective) |
| prot_sel | output | 1 | Register-controlled protection select |

## Verification
The assertions check the following on every cycle:
- the start pulse appears only on the step out of idle and lasts one cycle;
- a done strobe in busy always lands in the hidden state;
- the visible state is entered only from hidden, and idle only from visible;
- the memory-side data stays zero unless the result is visible;
- the error flag falls only on a clear write;
- the command registers read zero;
- the dual-key output never asserts at level zero.

Some behaviour only the bench's scenarios can show:
- which configurations a start rejects;
- that stray result writes outside busy are dropped;
- that a wipe really zeroes words a shorter later job does not overwrite;
- the exact ciphertext words presented after release.

// File: rtl/mce_pkg.sv
package mce_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_BUSY    = 2'd1,
        ST_HIDDEN  = 2'd2,
        ST_VISIBLE = 2'd3
    } mce_state_e;

    localparam logic [9:0] OFS_PT_BASE = 10'h300;
    localparam logic [9:0] OFS_LSIZE   = 10'h340;
    localparam logic [9:0] OFS_DEST    = 10'h344;
    localparam logic [9:0] OFS_ADDR    = 10'h348;
    localparam logic [9:0] OFS_TRIG    = 10'h34C;
    localparam logic [9:0] OFS_REL     = 10'h350;
    localparam logic [9:0] OFS_WIPE    = 10'h354;
    localparam logic [9:0] OFS_STAT    = 10'h358;
    localparam logic [9:0] OFS_VER     = 10'h35C;
    localparam logic [9:0] OFS_PROT    = 10'h388;

    localparam int          STAT_ERR_BIT = 8;
    localparam logic [29:0] VERSION_VAL  = 30'h20201010;
    localparam logic [4:0]  PROT_RST     = 5'h0F;

    // Line configuration check: code 3 is reserved, and the address must be
    // a multiple of the line's byte count (16, 32 or 64).
    function automatic logic line_ok(input logic [1:0] lsz, input logic [5:0] low);
        logic ok;
        case (lsz)
            2'd0:    ok = (low[3:0] == 4'd0);
            2'd1:    ok = (low[4:0] == 5'd0);
            2'd2:    ok = (low[5:0] == 6'd0);
            default: ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/mce_regs.sv
module mce_regs
    import mce_pkg::*;
#(
    parameter int ADDR_W   = 10,
    parameter int DATA_W   = 32,
    parameter int PADDR_W  = 26,
    parameter int PT_WORDS = 16,
    parameter int IDX_W    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  mce_state_e        state,
    input  logic              err,
    input  logic [IDX_W-1:0]  pt_idx,
    output logic [DATA_W-1:0] pt_data,
    output logic [1:0]        lsize,
    output logic              dest,
    output logic [PADDR_W-1:0] paddr,
    output logic [4:0]        prot,
    output logic              cmd_trig,
    output logic              cmd_rel,
    output logic              cmd_wipe,
    output logic              err_clr
);

    localparam int PT_OFS_W = IDX_W + 2;
    localparam logic [ADDR_W-1:0] A_PT    = ADDR_W'(OFS_PT_BASE);
    localparam logic [ADDR_W-1:0] A_LSIZE = ADDR_W'(OFS_LSIZE);
    localparam logic [ADDR_W-1:0] A_DEST  = ADDR_W'(OFS_DEST);
    localparam logic [ADDR_W-1:0] A_ADDR  = ADDR_W'(OFS_ADDR);
    localparam logic [ADDR_W-1:0] A_TRIG  = ADDR_W'(OFS_TRIG);
    localparam logic [ADDR_W-1:0] A_REL   = ADDR_W'(OFS_REL);
    localparam logic [ADDR_W-1:0] A_WIPE  = ADDR_W'(OFS_WIPE);
    localparam logic [ADDR_W-1:0] A_STAT  = ADDR_W'(OFS_STAT);
    localparam logic [ADDR_W-1:0] A_VER   = ADDR_W'(OFS_VER);
    localparam logic [ADDR_W-1:0] A_PROT  = ADDR_W'(OFS_PROT);

    logic [DATA_W-1:0] pt_mem [PT_WORDS];
    logic              pt_hit;
    logic [IDX_W-1:0]  bus_idx;

    assign pt_hit  = (bus_addr[ADDR_W-1:PT_OFS_W] == A_PT[ADDR_W-1:PT_OFS_W]);
    assign bus_idx = bus_addr[PT_OFS_W-1:2];

    // Command strobes: only a 1 in bit 0 of a command register counts.
    assign cmd_trig = bus_we && (bus_addr == A_TRIG) && bus_wdata[0];
    assign cmd_rel  = bus_we && (bus_addr == A_REL)  && bus_wdata[0];
    assign cmd_wipe = bus_we && (bus_addr == A_WIPE) && bus_wdata[0];
    assign err_clr  = bus_we && (bus_addr == A_STAT) && bus_wdata[STAT_ERR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PT_WORDS; i++) pt_mem[i] <= '0;
        end else if (bus_we && pt_hit) begin
            pt_mem[bus_idx] <= bus_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lsize <= 2'd0;
            dest  <= 1'b0;
            paddr <= '0;
            prot  <= PROT_RST;
        end else if (bus_we) begin
            if (bus_addr == A_LSIZE) lsize <= bus_wdata[1:0];
            if (bus_addr == A_DEST)  dest  <= bus_wdata[0];
            if (bus_addr == A_ADDR)  paddr <= bus_wdata[PADDR_W-1:0];
            if (bus_addr == A_PROT)  prot  <= bus_wdata[4:0];
        end
    end

    assign pt_data = pt_mem[pt_idx];

    always_comb begin
        bus_rdata = '0;
        if (pt_hit) begin
            bus_rdata = pt_mem[bus_idx];
        end else begin
            case (bus_addr)
                A_LSIZE: bus_rdata[1:0]         = lsize;
                A_DEST:  bus_rdata[0]           = dest;
                A_ADDR:  bus_rdata[PADDR_W-1:0] = paddr;
                A_STAT: begin
                    bus_rdata[1:0]          = state;
                    bus_rdata[STAT_ERR_BIT] = err;
                end
                A_VER:   bus_rdata[29:0]        = VERSION_VAL;
                A_PROT:  bus_rdata[4:0]         = prot;
                default: bus_rdata              = '0;
            endcase
        end
    end

endmodule

// File: rtl/mce_fsm.sv
module mce_fsm
    import mce_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_trig,
    input  logic       cmd_rel,
    input  logic       cmd_wipe,
    input  logic       err_clr,
    input  logic       cfg_ok,
    input  logic       eng_done,
    output mce_state_e state,
    output logic       err,
    output logic       eng_start,
    output logic       wipe,
    output logic       cap_en
);

    mce_state_e state_n;
    logic       bad;
    logic       launch;

    always_comb begin
        state_n = state;
        bad     = 1'b0;
        launch  = 1'b0;
        wipe    = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (cmd_trig) begin
                    if (cfg_ok) begin
                        state_n = ST_BUSY;
                        launch  = 1'b1;
                    end else begin
                        bad = 1'b1;
                    end
                end
                if (cmd_rel || cmd_wipe) bad = 1'b1;
            end
            ST_BUSY: begin
                if (eng_done) state_n = ST_HIDDEN;
                if (cmd_trig || cmd_rel || cmd_wipe) bad = 1'b1;
            end
            ST_HIDDEN: begin
                if (cmd_rel) state_n = ST_VISIBLE;
                if (cmd_trig || cmd_wipe) bad = 1'b1;
            end
            ST_VISIBLE: begin
                if (cmd_wipe) begin
                    state_n = ST_IDLE;
                    wipe    = 1'b1;
                end
                if (cmd_trig || cmd_rel) bad = 1'b1;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_start <= 1'b0;
            err       <= 1'b0;
        end else begin
            eng_start <= launch;
            if (bad)          err <= 1'b1;
            else if (err_clr) err <= 1'b0;
        end
    end

    assign cap_en = (state == ST_BUSY);

endmodule

// File: rtl/mce_resbuf.sv
module mce_resbuf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              cap_en,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              visible,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (wipe) begin
            for (int i = 0; i < WORDS; i++) mem[i] <= '0;
        end else if (cap_en && wr_en) begin
            mem[wr_idx] <= wr_data;
        end
    end

    assign rd_data = visible ? mem[rd_idx] : '0;

endmodule

// File: rtl/mce_ctrl.sv
module mce_ctrl
    import mce_pkg::*;
#(
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 32,
    parameter int PADDR_W   = 26,
    parameter int LINE_BYTES = 64,
    localparam int WORDS    = LINE_BYTES / 4,
    localparam int IDX_W    = $clog2(WORDS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_we,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [DATA_W-1:0]  bus_wdata,
    output logic [DATA_W-1:0]  bus_rdata,
    output logic               eng_start,
    output logic [1:0]         eng_lsize,
    output logic [PADDR_W-1:0] eng_paddr,
    output logic               eng_dest,
    input  logic [IDX_W-1:0]   eng_pt_idx,
    output logic [DATA_W-1:0]  eng_pt_data,
    input  logic               eng_done,
    input  logic               eng_res_we,
    input  logic [IDX_W-1:0]   eng_res_idx,
    input  logic [DATA_W-1:0]  eng_res_data,
    output logic               mem_visible,
    input  logic [IDX_W-1:0]   mem_rd_idx,
    output logic [DATA_W-1:0]  mem_rd_data,
    output logic [2:0]         sec_level,
    output logic               dual_key_en,
    output logic               prot_sel
);

    mce_state_e state_q;
    logic       err_q;
    logic       cmd_trig, cmd_rel, cmd_wipe, err_clr;
    logic       cfg_ok, wipe, cap_en;
    logic [4:0] prot;

    mce_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PADDR_W(PADDR_W),
        .PT_WORDS(WORDS), .IDX_W(IDX_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .state(state_q), .err(err_q),
        .pt_idx(eng_pt_idx), .pt_data(eng_pt_data),
        .lsize(eng_lsize), .dest(eng_dest), .paddr(eng_paddr), .prot(prot),
        .cmd_trig(cmd_trig), .cmd_rel(cmd_rel), .cmd_wipe(cmd_wipe),
        .err_clr(err_clr)
    );

    assign cfg_ok = line_ok(eng_lsize, eng_paddr[5:0]);

    mce_fsm u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cmd_trig(cmd_trig), .cmd_rel(cmd_rel), .cmd_wipe(cmd_wipe),
        .err_clr(err_clr), .cfg_ok(cfg_ok), .eng_done(eng_done),
        .state(state_q), .err(err_q), .eng_start(eng_start),
        .wipe(wipe), .cap_en(cap_en)
    );

    assign mem_visible = (state_q == ST_VISIBLE);

    mce_resbuf #(.DATA_W(DATA_W), .WORDS(WORDS), .IDX_W(IDX_W)) u_res (
        .clk(clk), .rst_n(rst_n),
        .wipe(wipe), .cap_en(cap_en),
        .wr_en(eng_res_we), .wr_idx(eng_res_idx), .wr_data(eng_res_data),
        .visible(mem_visible), .rd_idx(mem_rd_idx), .rd_data(mem_rd_data)
    );

    assign sec_level   = prot[2:0];
    assign dual_key_en = prot[3] && (prot[2:0] != 3'd0);
    assign prot_sel    = prot[4];

endmodule

// File: rtl/mce_ctrl_chk.sv
module mce_ctrl_chk
    import mce_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input mce_state_e        state,
    input logic              err,
    input logic              eng_start,
    input logic              eng_done,
    input logic              mem_visible,
    input logic [DATA_W-1:0] mem_rd_data,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [DATA_W-1:0] bus_rdata,
    input logic [2:0]        sec_level,
    input logic              dual_key_en
);

    assert_start_from_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> (state == ST_BUSY && $past(state) == ST_IDLE));

    assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    assert_done_to_hidden_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUSY && eng_done) |=> (state == ST_HIDDEN));

    assert_dark_unless_visible_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_visible |-> (mem_rd_data == '0));

    assert_visible_from_hidden_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_VISIBLE && $past(state) != ST_VISIBLE) |-> ($past(state) == ST_HIDDEN));

    assert_idle_from_visible_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && $past(state) != ST_IDLE) |-> ($past(state) == ST_VISIBLE));

    assert_err_clear_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(err) && !err) |->
            $past(bus_we && bus_addr == ADDR_W'(OFS_STAT) && bus_wdata[STAT_ERR_BIT]));

    assert_cmd_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(OFS_TRIG) || bus_addr == ADDR_W'(OFS_REL) ||
         bus_addr == ADDR_W'(OFS_WIPE)) |-> (bus_rdata == '0));

    assert_dual_needs_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
        dual_key_en |-> (sec_level != 3'd0));

endmodule

bind mce_ctrl mce_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .state(state_q), .err(err_q),
    .eng_start(eng_start), .eng_done(eng_done),
    .mem_visible(mem_visible), .mem_rd_data(mem_rd_data),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .sec_level(sec_level), .dual_key_en(dual_key_en)
);

// File: tb/mce_ctrl_bench.sv
`timescale 1ns/1ps
module mce_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_start;
    logic [1:0]  eng_lsize;
    logic [25:0] eng_paddr;
    logic        eng_dest;
    logic [3:0]  eng_pt_idx = '0;
    logic [31:0] eng_pt_data;
    logic        eng_done = 1'b0;
    logic        eng_res_we = 1'b0;
    logic [3:0]  eng_res_idx = '0;
    logic [31:0] eng_res_data = '0;
    logic        mem_visible;
    logic [3:0]  mem_rd_idx = '0;
    logic [31:0] mem_rd_data;
    logic [2:0]  sec_level;
    logic        dual_key_en;
    logic        prot_sel;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mce_ctrl u_mce_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_lsize(eng_lsize), .eng_paddr(eng_paddr), .eng_dest(eng_dest),
        .eng_pt_idx(eng_pt_idx), .eng_pt_data(eng_pt_data), .eng_done(eng_done),
        .eng_res_we(eng_res_we), .eng_res_idx(eng_res_idx),
        .eng_res_data(eng_res_data), .mem_visible(mem_visible),
        .mem_rd_idx(mem_rd_idx), .mem_rd_data(mem_rd_data),
        .sec_level(sec_level), .dual_key_en(dual_key_en), .prot_sel(prot_sel)
    );

    // ---------------- reference model ----------------
    int          m_state;
    bit          m_err, m_start, m_dest;
    logic [1:0]  m_lsize;
    logic [25:0] m_addr;
    logic [4:0]  m_prot;
    logic [31:0] m_pt  [16];
    logic [31:0] m_res [16];

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_state <= 0; m_err <= 0; m_start <= 0; m_dest <= 0;
            m_lsize <= 0; m_addr <= 0; m_prot <= 5'h0F;
            for (int k = 0; k < 16; k++) begin m_pt[k] <= 0; m_res[k] <= 0; end
        end else begin
            m_start <= 0;
            if (eng_done && m_state == 1) m_state <= 2;
            if (eng_res_we && m_state == 1) m_res[eng_res_idx] <= eng_res_data;
            if (bus_we) begin
                if (bus_addr >= 10'h300 && bus_addr < 10'h340) m_pt[bus_addr[5:2]] <= bus_wdata;
                case (bus_addr)
                    10'h340: m_lsize <= bus_wdata[1:0];
                    10'h344: m_dest  <= bus_wdata[0];
                    10'h348: m_addr  <= bus_wdata[25:0];
                    10'h388: m_prot  <= bus_wdata[4:0];
                    10'h358: if (bus_wdata[8]) m_err <= 0;
                    10'h34C: if (bus_wdata[0]) begin
                        if (m_state == 0 && m_lsize != 3 &&
                            (int'(m_addr) % (16 << m_lsize)) == 0) begin
                            m_state <= 1; m_start <= 1;
                        end else m_err <= 1;
                    end
                    10'h350: if (bus_wdata[0]) begin
                        if (m_state == 2) m_state <= 3; else m_err <= 1;
                    end
                    10'h354: if (bus_wdata[0]) begin
                        if (m_state == 3) begin
                            m_state <= 0;
                            for (int k = 0; k < 16; k++) m_res[k] <= 0;
                        end else m_err <= 1;
                    end
                    default: ;
                endcase
            end
        end
    end

    function automatic logic [31:0] model_read(input logic [9:0] a);
        logic [31:0] r = 0;
        if (a >= 10'h300 && a < 10'h340) return m_pt[a[5:2]];
        case (a)
            10'h340: r[1:0]  = m_lsize;
            10'h344: r[0]    = m_dest;
            10'h348: r[25:0] = m_addr;
            10'h358: begin r[1:0] = 2'(m_state); r[8] = m_err; end
            10'h35C: r = 32'h20201010;
            10'h388: r[4:0]  = m_prot;
            default: r = 0;
        endcase
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model, away from the clock edge
    always begin
        @(negedge clk); #1;
        if (rst_n) begin
            chk(eng_start === m_start, "R2 start pulse", 32'(eng_start), 32'(m_start));
            chk(mem_visible === (m_state == 3), "R4 visible", 32'(mem_visible), 32'(m_state == 3));
            chk(mem_rd_data === ((m_state == 3) ? m_res[mem_rd_idx] : 32'h0), "R4 mem data",
                mem_rd_data, (m_state == 3) ? m_res[mem_rd_idx] : 32'h0);
            chk(bus_rdata === model_read(bus_addr), "R9 readback", bus_rdata, model_read(bus_addr));
            chk(dual_key_en === (m_prot[3] && m_prot[2:0] != 0), "R10 dual key",
                32'(dual_key_en), 32'(m_prot[3] && m_prot[2:0] != 0));
            chk({prot_sel, sec_level} === {m_prot[4], m_prot[2:0]}, "R10 level/select",
                32'({prot_sel, sec_level}), 32'({m_prot[4], m_prot[2:0]}));
        end
    end

    // ---------------- cipher engine stub ----------------
    initial begin
        forever begin
            @(negedge clk);
            if (eng_start === 1'b1) begin
                for (int i = 0; i < (4 << eng_lsize); i++) begin
                    eng_pt_idx = 4'(i);
                    #1;
                    chk(eng_pt_data === m_pt[i], "R11 plaintext port", eng_pt_data, m_pt[i]);
                    eng_res_we   = 1'b1;
                    eng_res_idx  = 4'(i);
                    eng_res_data = eng_pt_data ^ 32'hC3C3_0000 ^ 32'(i);
                    @(negedge clk);
                end
                eng_res_we = 1'b0;
                repeat (3) @(negedge clk);
                eng_done = 1'b1;
                @(negedge clk);
                eng_done = 1'b0;
                // Stray write outside busy: must be dropped (R3)
                eng_res_we = 1'b1; eng_res_idx = 4'd15; eng_res_data = 32'hDEAD_BEEF;
                @(negedge clk);
                eng_res_we = 1'b0;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic bus_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic expect_read(input logic [9:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        chk(bus_rdata === exp, tag, bus_rdata, exp);
    endtask

    task automatic wait_state(input logic [1:0] s, input string tag);
        logic [31:0] v = 0;
        for (int t = 0; t < 200; t++) begin
            @(negedge clk);
            bus_addr = 10'h358;
            #1;
            v = bus_rdata;
            if (v[1:0] == s) break;
        end
        chk(v[1:0] == s, tag, v, 32'(s));
    endtask

    function automatic logic [31:0] pat(input int job, input int i);
        return 32'h0A00_0000 * job + (32'(i) << 16) + 32'(i * 3);
    endfunction

    task automatic check_results(input int job, input int nw, input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            mem_rd_idx = 4'(i);
            #1;
            if (i < nw) chk(mem_rd_data === (pat(job, i) ^ 32'hC3C3_0000 ^ 32'(i)), tag,
                            mem_rd_data, pat(job, i) ^ 32'hC3C3_0000 ^ 32'(i));
            else        chk(mem_rd_data === 32'h0, tag, mem_rd_data, 32'h0);
        end
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        expect_read(10'h358, 32'h0, "R1 status");
        expect_read(10'h35C, 32'h2020_1010, "R1 version");
        expect_read(10'h388, 32'h0F, "R1 protection");
        expect_read(10'h340, 32'h0, "R1 line size");
        expect_read(10'h348, 32'h0, "R1 address");
        expect_read(10'h344, 32'h0, "R1 destination");
        chk(sec_level == 3'd7 && dual_key_en && !prot_sel, "R1 protection outputs",
            32'({prot_sel, dual_key_en, sec_level}), 32'h0F);

        // R6 illegal release in idle, then clear
        bus_write(10'h350, 32'h1);
        expect_read(10'h358, 32'h100, "R6 release in idle");
        bus_write(10'h358, 32'h100);
        expect_read(10'h358, 32'h0, "R6 error cleared");

        // R8 zero-bit command writes do nothing
        bus_write(10'h34C, 32'hFFFF_FFFE);
        bus_write(10'h354, 32'h0);
        expect_read(10'h358, 32'h0, "R8 zero command ignored");
        expect_read(10'h34C, 32'h0, "R8 command reads zero");

        // plaintext for job 1 and R9 readback
        for (int i = 0; i < 16; i++) bus_write(10'h300 + 10'(4 * i), pat(1, i));
        expect_read(10'h304, pat(1, 1), "R9 plaintext readback");
        bus_write(10'h344, 32'h1);
        expect_read(10'h344, 32'h1, "R9 destination");
        bus_write(10'h344, 32'h0);

        // R7 rejected starts
        bus_write(10'h340, 32'h3);
        bus_write(10'h34C, 32'h1);
        expect_read(10'h358, 32'h100, "R7 reserved line size");
        bus_write(10'h358, 32'h100);
        bus_write(10'h340, 32'h2);
        bus_write(10'h348, 32'h20);
        bus_write(10'h34C, 32'h1);
        expect_read(10'h358, 32'h100, "R7 misaligned address");
        bus_write(10'h358, 32'h100);

        // R2 valid start, 64-byte line
        bus_write(10'h348, 32'h40);
        bus_write(10'h34C, 32'h1);
        expect_read(10'h358, 32'h1, "R2 busy after start");
        bus_write(10'h354, 32'h1);
        expect_read(10'h358, 32'h101, "R6 wipe in busy refused");
        bus_write(10'h358, 32'h100);

        // R3 completion, hidden
        wait_state(2'd2, "R3 done to hidden");
        @(negedge clk); mem_rd_idx = 4'd0; #1;
        chk(mem_visible === 1'b0 && mem_rd_data === 32'h0, "R4 hidden is dark",
            mem_rd_data, 32'h0);
        bus_write(10'h354, 32'h1);
        expect_read(10'h358, 32'h102, "R6 wipe in hidden refused");
        bus_write(10'h358, 32'h100);

        // R5 release, R3 contents
        bus_write(10'h350, 32'h1);
        expect_read(10'h358, 32'h3, "R5 release to visible");
        check_results(1, 16, "R3 job1 result");
        bus_write(10'h34C, 32'h1);
        expect_read(10'h358, 32'h103, "R6 start in visible refused");
        bus_write(10'h358, 32'h100);
        bus_write(10'h354, 32'h1);
        expect_read(10'h358, 32'h0, "R5 wipe to idle");

        // job 2: 16-byte line, shows the wipe cleared the upper words
        for (int i = 0; i < 4; i++) bus_write(10'h300 + 10'(4 * i), pat(2, i));
        bus_write(10'h340, 32'h0);
        bus_write(10'h348, 32'h10);
        bus_write(10'h34C, 32'h1);
        wait_state(2'd2, "R3 job2 hidden");
        bus_write(10'h350, 32'h1);
        check_results(2, 4, "R5 wipe cleared buffer");
        bus_write(10'h354, 32'h1);

        // R10 protection gating
        bus_write(10'h388, 32'h08);
        @(negedge clk); #1;
        chk(dual_key_en === 1'b0 && sec_level == 3'd0, "R10 level zero gates dual",
            32'(dual_key_en), 32'h0);
        bus_write(10'h388, 32'h13);
        @(negedge clk); #1;
        chk(prot_sel && sec_level == 3'd3 && !dual_key_en, "R10 select and level",
            32'({prot_sel, dual_key_en, sec_level}), 32'h13);
        bus_write(10'h388, 32'h0B);
        @(negedge clk); #1;
        chk(dual_key_en === 1'b1, "R10 dual enabled", 32'(dual_key_en), 32'h1);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule